// File: doc/BRIEF.md
# SDRAM Command and Address Issuer

This block sits on the controller side of a 16-bit SDRAM interface. It takes one request at a time over a valid/ready handshake (activate a row, read, write, precharge one bank, precharge every bank, load the mode register, or do nothing). On the next rising clock edge it turns the request into registered pin states: chip select, the three command strobes, the two bank bits and the 13-bit multiplexed address bus. The pins are registered so that the memory can sample them on the following edge. CKE is held high throughout. A cycle with no accepted request drives a no-operation.

The block also registers a per-byte-lane mask to the two DQM pins. During a write, a high DQM bit masks that lane in the same cycle. During a read, the memory takes two clocks to turn the lane's output off. To let the read data path know which returning beats are blanked, the block gives a copy of the DQM pins delayed by two stages. Timing between commands, refresh scheduling and the data path are the job of other blocks.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: While rst_n is low at a rising edge, the outputs become: cs_n=1, ras_n=1, cas_n=1, we_n=1, ba=0, addr=0, cke=1, dqm=2'b11, rd_lane_off=2'b11 and req_ready=0.
- R2: In any cycle after reset with no accepted request, the next edge drives NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), with ba=0 and addr=0.
- R3: An accepted ACTIVE request (req_kind=1) drives 0,0,1,1 on cs_n,ras_n,cas_n,we_n, the row on addr[12:0] and the bank on ba, on the edge that accepts it.
- R4: An accepted READ (req_kind=2) drives 0,1,0,1, and an accepted WRITE (req_kind=3) drives 0,1,0,0. Both put the column on addr[9:0], the auto-precharge flag on addr[10], zeros on addr[12:11] and the bank on ba.
- R5: An accepted single-bank PRECHARGE (req_kind=4) drives 0,0,1,0 with addr[10]=0 and the bank on ba. The other address bits are 0.
- R6: An accepted PRECHARGE-ALL (req_kind=5) drives 0,0,1,0 with addr[10]=1, all other address bits 0 and ba=0, whatever the request's bank is.
- R7: An accepted LOAD MODE (req_kind=6) drives 0,0,0,0 with the opcode on addr[12:0] and ba=0.
- R8: A request with req_kind=0 (NOP) or with the reserved code 7 drives a NOP, exactly as R2 describes.
- R9: The dqm pins take the value of lane_mask (bit 0 for DQ0–7, bit 1 for DQ8–15) one edge after it is presented.
- R10: rd_lane_off equals the value dqm held two clocks earlier, lane by lane.
- R11: req_ready is high in every cycle after the first edge out of reset. Each accepted request produces exactly one command cycle, and the cycle after it is a NOP unless another request is accepted.
- R12: cke stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block accepts a request this cycle |
| req_kind | input | 3 | Request code (0 NOP, 1 activate, 2 read, 3 write, 4 precharge one, 5 precharge all, 6 load mode, 7 reserved) |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Row address for activate |
| req_col | input | 10 | Column address for read/write |
| req_auto_pre | input | 1 | Auto-precharge flag for read/write |
| req_mode | input | 13 | Mode register opcode |
| lane_mask | input | 2 | Per-lane mask to drive on DQM |
| sd_cke | output | 1 | Clock enable pin |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address pins |
| sd_addr | output | 13 | Multiplexed address pins |
| sd_dqm | output | 2 | Byte-lane mask pins |
| rd_lane_off | output | 2 | DQM delayed two clocks: lanes blanked in read data |

## Verification
The bench goes after the uses of address bit 10, which change with the command. Precharge-all with a nonzero requested bank must come out with ba=0. If a design forgot to clear the bank, the command would still work, but ba would carry a stale value. READ and WRITE with the flag set must show it on bit 10 only, with bits 12:11 at zero. If a design copied row-width data, junk would appear in the high bits. The bench also checks that the cycle after every command falls back to NOP: a design with a sticky command register would issue the command twice. It checks that reserved code 7 is harmless. Finally, it follows a mask pattern through dqm and rd_lane_off. A pipeline one stage short or one stage long would blank the wrong read beat.

// File: rtl/sdram_cmd_pkg.sv
// Shared widths, request codes and the pin bundle for the SDRAM command issuer.
// Assumes a 16-bit data bus organisation: two byte lanes, ten column bits.
package sdram_cmd_pkg;
    localparam int ADDR_W = 13;
    localparam int BANK_W = 2;
    localparam int COL_W  = 10;
    localparam int AP_BIT = 10;
    localparam int LANES  = 2;

    typedef enum logic [2:0] {
        RK_NOP     = 3'd0,
        RK_ACT     = 3'd1,
        RK_READ    = 3'd2,
        RK_WRITE   = 3'd3,
        RK_PRE     = 3'd4,
        RK_PRE_ALL = 3'd5,
        RK_LMR     = 3'd6,
        RK_RSVD    = 3'd7
    } req_kind_t;

    typedef struct packed {
        logic              cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
    } pin_set_t;

    localparam pin_set_t PINS_DESELECT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                           we_n: 1'b1, ba: '0, addr: '0};
    localparam pin_set_t PINS_NOP      = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1,
                                           we_n: 1'b1, ba: '0, addr: '0};
endpackage

// File: rtl/sdram_cmd_encode.sv
// Combinational translation of one request into command strobes, bank and
// address. Assumes the column fits below the auto-precharge bit.
module sdram_cmd_encode
    import sdram_cmd_pkg::*;
#(
    parameter int ROW_W = ADDR_W,
    parameter int CW    = COL_W
) (
    input  logic [2:0]        kind,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [CW-1:0]     col,
    input  logic              auto_pre,
    input  logic [ADDR_W-1:0] mode,
    output pin_set_t          pins
);
    // Choose strobes and lay out the address bus for the request kind.
    always_comb begin
        pins = PINS_NOP;
        case (req_kind_t'(kind))
            RK_ACT: begin
                pins.ras_n = 1'b0;
                pins.ba    = bank;
                pins.addr  = ADDR_W'(row);
            end
            RK_READ, RK_WRITE: begin
                pins.cas_n            = 1'b0;
                pins.we_n             = (req_kind_t'(kind) == RK_READ);
                pins.ba               = bank;
                pins.addr[CW-1:0]     = col;
                pins.addr[AP_BIT]     = auto_pre;
            end
            RK_PRE: begin
                pins.ras_n = 1'b0;
                pins.we_n  = 1'b0;
                pins.ba    = bank;
            end
            RK_PRE_ALL: begin
                pins.ras_n        = 1'b0;
                pins.we_n         = 1'b0;
                pins.addr[AP_BIT] = 1'b1;
            end
            RK_LMR: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
                pins.we_n  = 1'b0;
                pins.addr  = mode;
            end
            default: pins = PINS_NOP;
        endcase
    end
endmodule

// File: rtl/sdram_dqm_pipe.sv
// Per-lane shift pipeline giving the DQM pins delayed by DEPTH clocks, which
// marks the read beats the memory leaves in high impedance. Assumes DEPTH >= 2.
module sdram_dqm_pipe #(
    parameter int N_LANE = 2,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LANE-1:0] dqm_in,
    output logic [N_LANE-1:0] dqm_late
);
    for (genvar ln = 0; ln < N_LANE; ln++) begin : g_lane
        logic [DEPTH-1:0] stage;
        // Shift one lane's mask bit through DEPTH registers; reset to masked.
        always_ff @(posedge clk) begin
            if (!rst_n) stage <= '1;
            else        stage <= {stage[DEPTH-2:0], dqm_in[ln]};
        end
        assign dqm_late[ln] = stage[DEPTH-1];
    end

    // Cycles since reset, saturating; used only by the checks below.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    if (DEPTH == 2) begin : g_chk
        a_r10_two_clock_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2) |-> (dqm_late == $past(dqm_in, 2)));
    end
endmodule

// File: rtl/sdram_cmd_issuer.sv
// Registers one SDRAM command per accepted request onto the pins, drives a
// NOP when idle, and carries the per-lane DQM plus its delayed read copy.
// Assumes the caller spaces commands to meet the memory's timing.
module sdram_cmd_issuer
    import sdram_cmd_pkg::*;
#(
    parameter int DQM_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_auto_pre,
    input  logic [ADDR_W-1:0] req_mode,
    input  logic [LANES-1:0]  lane_mask,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [LANES-1:0]  sd_dqm,
    output logic [LANES-1:0]  rd_lane_off
);
    pin_set_t enc_pins;
    pin_set_t pin_q;
    logic     take;

    sdram_cmd_encode #(.ROW_W(ADDR_W), .CW(COL_W)) u_enc (
        .kind     (req_kind),
        .bank     (req_bank),
        .row      (req_row),
        .col      (req_col),
        .auto_pre (req_auto_pre),
        .mode     (req_mode),
        .pins     (enc_pins)
    );

    assign take = req_valid && req_ready;

    // Register the command pins: deselect in reset, the request when taken, else NOP.
    always_ff @(posedge clk) begin
        if (!rst_n)    pin_q <= PINS_DESELECT;
        else if (take) pin_q <= enc_pins;
        else           pin_q <= PINS_NOP;
    end

    // Register handshake, clock enable and lane mask pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_ready <= 1'b0;
            sd_cke    <= 1'b1;
            sd_dqm    <= '1;
        end else begin
            req_ready <= 1'b1;
            sd_cke    <= 1'b1;
            sd_dqm    <= lane_mask;
        end
    end

    sdram_dqm_pipe #(.N_LANE(LANES), .DEPTH(DQM_LAT)) u_dqm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dqm_in   (sd_dqm),
        .dqm_late (rd_lane_off)
    );

    assign sd_cs_n  = pin_q.cs_n;
    assign sd_ras_n = pin_q.ras_n;
    assign sd_cas_n = pin_q.cas_n;
    assign sd_we_n  = pin_q.we_n;
    assign sd_ba    = pin_q.ba;
    assign sd_addr  = pin_q.addr;

    // Cycles since reset, saturating; used only by the checks below.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r12_cke_high: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) |-> sd_cke);
    a_r11_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) |-> req_ready);
    a_r2_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) && !req_valid |=> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n));
    a_r4_col_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && sd_ras_n && !sd_cas_n) |-> (sd_addr[ADDR_W-1:AP_BIT+1] == '0));
    a_r6_pre_all_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n && sd_addr[AP_BIT]) |-> (sd_ba == '0));
    a_r9_dqm_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) |=> (sd_dqm == $past(lane_mask)));
endmodule

// File: tb/sdram_cmd_issuer_test.sv
module sdram_cmd_issuer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_auto_pre = 1'b0;
    logic [12:0] req_mode = '0;
    logic [1:0]  lane_mask = 2'b00;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [1:0]  sd_dqm, rd_lane_off;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_issuer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_auto_pre(req_auto_pre), .req_mode(req_mode),
        .lane_mask(lane_mask), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .rd_lane_off(rd_lane_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    // Present one request for a single cycle; returns with pins showing it.
    task automatic issue(input logic [2:0] k, input logic [1:0] b, input logic [12:0] row,
                         input logic [9:0] col, input logic ap, input logic [12:0] mode);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_bank = b; req_row = row;
        req_col = col; req_auto_pre = ap; req_mode = mode;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 strobes", 32'(strobes()), 32'hF);
        check("R1 ba/addr", {17'd0, sd_ba, sd_addr}, 32'd0);
        check("R1 dqm", 32'(sd_dqm), 32'h3);
        check("R1 rd_lane_off", 32'(rd_lane_off), 32'h3);
        check("R1 cke", 32'(sd_cke), 32'h1);
        check("R1 ready", 32'(req_ready), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 ready", 32'(req_ready), 32'h1);
        check("R2 idle nop", {15'd0, strobes(), sd_ba, sd_addr}, 32'(4'b0111) << 15);
    endtask

    task automatic t_activate();
        issue(3'd1, 2'd2, 13'h1ABC, 10'd0, 1'b0, 13'd0);
        check("R3 strobes", 32'(strobes()), 32'(4'b0011));
        check("R3 ba", 32'(sd_ba), 32'd2);
        check("R3 row", 32'(sd_addr), 32'h1ABC);
        @(negedge clk);
        check("R11 next nop", 32'(strobes()), 32'(4'b0111));
    endtask

    task automatic t_read_write();
        issue(3'd2, 2'd1, 13'h1FFF, 10'h3FF, 1'b1, 13'd0);
        check("R4 read strobes", 32'(strobes()), 32'(4'b0101));
        check("R4 read addr ap", 32'(sd_addr), 32'h07FF);
        check("R4 read ba", 32'(sd_ba), 32'd1);
        issue(3'd3, 2'd3, 13'h1FFF, 10'h155, 1'b0, 13'h1FFF);
        check("R4 write strobes", 32'(strobes()), 32'(4'b0100));
        check("R4 write addr", 32'(sd_addr), 32'h0155);
        check("R4 write ba", 32'(sd_ba), 32'd3);
    endtask

    task automatic t_precharge();
        issue(3'd4, 2'd3, 13'h1FFF, 10'h3FF, 1'b1, 13'h1FFF);
        check("R5 strobes", 32'(strobes()), 32'(4'b0010));
        check("R5 addr", 32'(sd_addr), 32'h0);
        check("R5 ba", 32'(sd_ba), 32'd3);
        issue(3'd5, 2'd3, 13'h1FFF, 10'h3FF, 1'b0, 13'h1FFF);
        check("R6 strobes", 32'(strobes()), 32'(4'b0010));
        check("R6 addr", 32'(sd_addr), 32'h0400);
        check("R6 ba", 32'(sd_ba), 32'd0);
    endtask

    task automatic t_load_mode();
        issue(3'd6, 2'd2, 13'h0, 10'h0, 1'b0, 13'h0A37);
        check("R7 strobes", 32'(strobes()), 32'(4'b0000));
        check("R7 opcode", 32'(sd_addr), 32'h0A37);
        check("R7 ba", 32'(sd_ba), 32'd0);
    endtask

    task automatic t_nop_codes();
        issue(3'd7, 2'd3, 13'h1FFF, 10'h3FF, 1'b1, 13'h1FFF);
        check("R8 reserved", {15'd0, strobes(), sd_ba, sd_addr}, 32'(4'b0111) << 15);
        issue(3'd0, 2'd3, 13'h1FFF, 10'h3FF, 1'b1, 13'h1FFF);
        check("R8 nop code", {15'd0, strobes(), sd_ba, sd_addr}, 32'(4'b0111) << 15);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd1; req_bank = 2'd1; req_row = 13'h0123;
        @(negedge clk);
        check("R11 first", 32'(strobes()), 32'(4'b0011));
        req_kind = 3'd2; req_col = 10'h012; req_auto_pre = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 second", {strobes(), sd_addr}, {15'd0, 4'b0101, 13'h0012});
        @(negedge clk);
        check("R11 single issue", 32'(strobes()), 32'(4'b0111));
    endtask

    task automatic t_dqm();
        logic [1:0] pat [4] = '{2'b01, 2'b10, 2'b00, 2'b11};
        @(negedge clk);
        lane_mask = pat[0];
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            check("R9 dqm pin", 32'(sd_dqm), 32'(pat[i-1]));
            if (i >= 3) check("R10 rd_lane_off", 32'(rd_lane_off), 32'(pat[i-3]));
            lane_mask = pat[i];
        end
        @(negedge clk);
        check("R9 dqm pin", 32'(sd_dqm), 32'(pat[3]));
        check("R10 rd_lane_off", 32'(rd_lane_off), 32'(pat[1]));
        @(negedge clk);
        check("R10 rd_lane_off", 32'(rd_lane_off), 32'(pat[2]));
        @(negedge clk);
        check("R10 rd_lane_off", 32'(rd_lane_off), 32'(pat[3]));
        check("R12 cke", 32'(sd_cke), 32'h1);
    endtask

    initial begin
        t_reset();
        t_activate();
        t_read_write();
        t_precharge();
        t_load_mode();
        t_nop_codes();
        t_back_to_back();
        t_dqm();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule